// File: doc/BRIEF.md
# GPIO Bank with Alternate-Function Routing

This block is one bank of general-purpose pins, 32 by default, controlled through a small word-wide register bus. For every pin it holds an output level, a direction, a pull-off flag and a two-bit function code. The output level and the direction are never written whole. One address sets the bits written as 1, and a second address clears them. A per-pin router connects each pad either to the bank's own GPIO logic or to one of three peripheral function ports.

A sleep override input, `force_sleep`, can move pins back to GPIO control while the system sleeps. Each pin has a keep bit. Pins whose keep bit is 0 fall back to GPIO while the override is high. Pins whose keep bit is 1 keep their selected function. When the override drops, every pin returns at once to the function its code selects.

The pull direction has no register of its own. It is taken from the pin's output-level bit. Pad inputs pass through a two-stage synchronizer. The synchronized levels can be read on the bus and are also driven out to neighbouring blocks such as an edge detector.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output level register is 0 and the direction register is 0 (all pins are inputs). Both function-select registers are 0 (GPIO), the pull-off register is 0 (all pulls on) and the keep register is all 1s. As a result, `pad_oe` is 0, `pad_pull_en` is all 1s and `pad_pull_up` is 0.
- R2: A write to address 1 (output set) sets each output-level bit whose data bit is 1 and leaves the others as they were. Reading address 1 or 2 returns the output level register.
- R3: A write to address 2 (output clear) clears each output-level bit whose data bit is 1 and leaves the others as they were.
- R4: A write to address 3 makes the pins with a 1 bit outputs, and a write to address 4 makes them inputs. Reading address 3 or 4 returns the direction register. A pin routed to GPIO drives `pad_out` from its output-level bit and `pad_oe` from its direction bit.
- R5: Address 5 (select low) and address 6 (select high) are read/write. Pin i uses the code {high[i], low[i]}: 00 selects GPIO, 01 port A, 10 port B and 11 port C. A peripheral route takes both `pad_out` and `pad_oe` from the chosen port.
- R6: Address 7 (pull-off) is read/write. `pad_pull_en[i]` is the inverse of pull-off bit i, and `pad_pull_up[i]` equals output-level bit i.
- R7: While `force_sleep` is 1, every pin whose keep bit (address 8, read/write) is 0 is routed to GPIO, whatever its select code.
- R8: While `force_sleep` is 1, every pin whose keep bit is 1 keeps the route given by its select code.
- R9: When `force_sleep` returns to 0, all pins take their select-code route in the same cycle. No clock edge is needed.
- R10: Reading address 0, and the `pin_level` output, give the pad levels after two register stages. A change at the pads shows up after the second rising clock edge, not after the first.
- R11: A write to address 0 or to any address above 8 changes no register. A read of an address above 8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW (4) | Register word address |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Read data for bus_addr, combinational |
| force_sleep | input | 1 | Sleep override of the pin routing |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pull_en | output | NPINS | Pull enable |
| pad_pull_up | output | NPINS | Pull direction, 1 for up and 0 for down |
| pin_level | output | NPINS | Synchronized pad levels |
| pa_out | input | NPINS | Port A output values |
| pa_oe | input | NPINS | Port A output enables |
| pb_out | input | NPINS | Port B output values |
| pb_oe | input | NPINS | Port B output enables |
| pc_out | input | NPINS | Port C output values |
| pc_oe | input | NPINS | Port C output enables |

## Verification
The routing is swept over many pseudo-random select words. With these words all four codes appear on different pins at the same time, so a swapped code or a swapped port shows up as a wrong bit. Each select setting is tried with the override low, then high against a mixed keep mask, then low again with no clock edge in between. This separates forced pins from kept pins and shows that the return is immediate. Overlapping set and clear words reveal any set or clear that disturbs bits outside its mask. A single pad step checked after one edge and after two confirms the synchronizer depth.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  localparam logic [3:0] REG_LEVEL = 4'd0;
  localparam logic [3:0] REG_OSET  = 4'd1;
  localparam logic [3:0] REG_OCLR  = 4'd2;
  localparam logic [3:0] REG_DSET  = 4'd3;
  localparam logic [3:0] REG_DCLR  = 4'd4;
  localparam logic [3:0] REG_SELLO = 4'd5;
  localparam logic [3:0] REG_SELHI = 4'd6;
  localparam logic [3:0] REG_PULLX = 4'd7;
  localparam logic [3:0] REG_KEEP  = 4'd8;

  typedef enum logic [1:0] {
    ROUTE_GPIO = 2'b00,
    ROUTE_PA   = 2'b01,
    ROUTE_PB   = 2'b10,
    ROUTE_PC   = 2'b11
  } route_e;

  // Effective route of one pin: sleep override wins unless the pin is kept.
  function automatic route_e pick_route(input logic lo, input logic hi,
                                        input logic frc, input logic keep);
    if (frc && !keep) return ROUTE_GPIO;
    return route_e'({hi, lo});
  endfunction

  // Set/clear merge used for the level and direction registers.
  function automatic logic [31:0] merge_sc(input logic [31:0] cur,
                                           input logic [31:0] mask,
                                           input logic        do_set,
                                           input logic        do_clr);
    logic [31:0] r;
    r = cur;
    if (do_set) r = r | mask;
    if (do_clr) r = r & ~mask;
    return r;
  endfunction

endpackage

// File: rtl/gpb_regs.sv
module gpb_regs #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] wdata,
  input  logic             wr_oset,
  input  logic             wr_oclr,
  input  logic             wr_dset,
  input  logic             wr_dclr,
  input  logic             wr_sello,
  input  logic             wr_selhi,
  input  logic             wr_pullx,
  input  logic             wr_keep,
  output logic [NPINS-1:0] dout_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] sello_q,
  output logic [NPINS-1:0] selhi_q,
  output logic [NPINS-1:0] pullx_q,
  output logic [NPINS-1:0] keep_q
);
  import gpb_pkg::*;

  logic [31:0] dout_w, dir_w, wd32, dout32, dir32;

  always_comb begin
    wd32   = '0;
    dout32 = '0;
    dir32  = '0;
    wd32[NPINS-1:0]   = wdata;
    dout32[NPINS-1:0] = dout_q;
    dir32[NPINS-1:0]  = dir_q;
    dout_w = merge_sc(dout32, wd32, wr_oset, wr_oclr);
    dir_w  = merge_sc(dir32, wd32, wr_dset, wr_dclr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      sello_q <= '0;
      selhi_q <= '0;
      pullx_q <= '0;
      keep_q  <= '1;
    end else begin
      dout_q <= dout_w[NPINS-1:0];
      dir_q  <= dir_w[NPINS-1:0];
      if (wr_sello) sello_q <= wdata;
      if (wr_selhi) selhi_q <= wdata;
      if (wr_pullx) pullx_q <= wdata;
      if (wr_keep)  keep_q  <= wdata;
    end
  end

  if (NPINS < 32) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^{dout_w[31:NPINS], dir_w[31:NPINS]};
  end

endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpb_pinmux.sv
module gpb_pinmux #(
  parameter int NPINS = 32
) (
  input  logic             force_sleep,
  input  logic [NPINS-1:0] sello,
  input  logic [NPINS-1:0] selhi,
  input  logic [NPINS-1:0] keep,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] pa_out,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pb_out,
  input  logic [NPINS-1:0] pb_oe,
  input  logic [NPINS-1:0] pc_out,
  input  logic [NPINS-1:0] pc_oe,
  output logic [NPINS-1:0] gpio_mask,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  import gpb_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    route_e rt;
    always_comb begin
      rt = pick_route(sello[i], selhi[i], force_sleep, keep[i]);
      gpio_mask[i] = (rt == ROUTE_GPIO);
      unique case (rt)
        ROUTE_GPIO: begin pad_out[i] = dout[i];   pad_oe[i] = dir[i];   end
        ROUTE_PA:   begin pad_out[i] = pa_out[i]; pad_oe[i] = pa_oe[i]; end
        ROUTE_PB:   begin pad_out[i] = pb_out[i]; pad_oe[i] = pb_oe[i]; end
        default:    begin pad_out[i] = pc_out[i]; pad_oe[i] = pc_oe[i]; end
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic             force_sleep,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pull_en,
  output logic [NPINS-1:0] pad_pull_up,
  output logic [NPINS-1:0] pin_level,
  input  logic [NPINS-1:0] pa_out,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pb_out,
  input  logic [NPINS-1:0] pb_oe,
  input  logic [NPINS-1:0] pc_out,
  input  logic [NPINS-1:0] pc_oe
);
  import gpb_pkg::*;

  localparam int SYNC_STAGES = 2;

  // Named decode events, visible to the bound checker.
  logic wr_oset, wr_oclr, wr_dset, wr_dclr, wr_sello, wr_selhi, wr_pullx, wr_keep;
  assign wr_oset  = bus_we && (bus_addr == AW'(REG_OSET));
  assign wr_oclr  = bus_we && (bus_addr == AW'(REG_OCLR));
  assign wr_dset  = bus_we && (bus_addr == AW'(REG_DSET));
  assign wr_dclr  = bus_we && (bus_addr == AW'(REG_DCLR));
  assign wr_sello = bus_we && (bus_addr == AW'(REG_SELLO));
  assign wr_selhi = bus_we && (bus_addr == AW'(REG_SELHI));
  assign wr_pullx = bus_we && (bus_addr == AW'(REG_PULLX));
  assign wr_keep  = bus_we && (bus_addr == AW'(REG_KEEP));

  logic [NPINS-1:0] dout_q, dir_q, sello_q, selhi_q, pullx_q, keep_q, gpio_mask;

  gpb_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .wr_oset(wr_oset), .wr_oclr(wr_oclr), .wr_dset(wr_dset), .wr_dclr(wr_dclr),
    .wr_sello(wr_sello), .wr_selhi(wr_selhi), .wr_pullx(wr_pullx), .wr_keep(wr_keep),
    .dout_q(dout_q), .dir_q(dir_q), .sello_q(sello_q), .selhi_q(selhi_q),
    .pullx_q(pullx_q), .keep_q(keep_q)
  );

  gpb_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_level)
  );

  gpb_pinmux #(.NPINS(NPINS)) u_mux (
    .force_sleep(force_sleep), .sello(sello_q), .selhi(selhi_q), .keep(keep_q),
    .dout(dout_q), .dir(dir_q),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe),
    .gpio_mask(gpio_mask), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pad_pull_en = ~pullx_q;
  assign pad_pull_up = dout_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(REG_LEVEL))                                bus_rdata = pin_level;
    else if (bus_addr == AW'(REG_OSET) || bus_addr == AW'(REG_OCLR)) bus_rdata = dout_q;
    else if (bus_addr == AW'(REG_DSET) || bus_addr == AW'(REG_DCLR)) bus_rdata = dir_q;
    else if (bus_addr == AW'(REG_SELLO))                           bus_rdata = sello_q;
    else if (bus_addr == AW'(REG_SELHI))                           bus_rdata = selhi_q;
    else if (bus_addr == AW'(REG_PULLX))                           bus_rdata = pullx_q;
    else if (bus_addr == AW'(REG_KEEP))                            bus_rdata = keep_q;
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             force_sleep,
  input logic             wr_oset,
  input logic             wr_oclr,
  input logic             wr_dset,
  input logic             wr_pullx,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] sello_q,
  input logic [NPINS-1:0] selhi_q,
  input logic [NPINS-1:0] keep_q,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pull_en,
  input logic [NPINS-1:0] pin_level
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  logic [NPINS-1:0] nat_gpio, forced;
  assign nat_gpio = ~sello_q & ~selhi_q;
  assign forced   = force_sleep ? ~keep_q : '0;

  AST_OSET_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oset |=> dout_q == ($past(dout_q) | $past(bus_wdata))); // R2
  AST_OCLR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oclr |=> dout_q == ($past(dout_q) & ~$past(bus_wdata))); // R3
  AST_DSET_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dset |=> dir_q == ($past(dir_q) | $past(bus_wdata))); // R4
  AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ dir_q) | (pad_out ^ dout_q)) & nat_gpio) == '0); // R4
  AST_FORCE_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ dir_q) | (pad_out ^ dout_q)) & forced) == '0); // R7
  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pullx |=> $stable(pad_pull_en)); // R6
  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2) |-> pin_level == $past(pad_in, 2)); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_sleep(force_sleep),
  .wr_oset(wr_oset), .wr_oclr(wr_oclr), .wr_dset(wr_dset), .wr_pullx(wr_pullx),
  .bus_wdata(bus_wdata), .dout_q(dout_q), .dir_q(dir_q),
  .sello_q(sello_q), .selhi_q(selhi_q), .keep_q(keep_q),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pull_en(pad_pull_en), .pin_level(pin_level)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = '0;
  logic bus_we = 0, force_sleep = 0;
  logic [N-1:0] bus_wdata = '0, pad_in = '0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe, pad_pull_en, pad_pull_up, pin_level;
  logic [N-1:0] pa_out = 32'h1357_9BDF, pa_oe = 32'hF0F0_0F0F;
  logic [N-1:0] pb_out = 32'h2468_ACE0, pb_oe = 32'h00FF_FF00;
  logic [N-1:0] pc_out = 32'h9C3E_61B5, pc_oe = 32'h5A5A_A5A5;

  int checks = 0, errors = 0;
  logic [N-1:0] m_dout, m_dir, m_lo, m_hi, m_pull, m_keep;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  gpio_bank u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .force_sleep(force_sleep),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pin_level(pin_level),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  // Expected pad drive, bit by bit from the requirement table.
  task automatic expect_pads(input logic f, output logic [N-1:0] eo, output logic [N-1:0] ee);
    for (int i = 0; i < N; i++) begin
      int code;
      code = (f && !m_keep[i]) ? 0 : 2 * m_hi[i] + m_lo[i];
      case (code)
        0: begin eo[i] = m_dout[i]; ee[i] = m_dir[i]; end
        1: begin eo[i] = pa_out[i]; ee[i] = pa_oe[i]; end
        2: begin eo[i] = pb_out[i]; ee[i] = pb_oe[i]; end
        default: begin eo[i] = pc_out[i]; ee[i] = pc_oe[i]; end
      endcase
    end
  endtask

  task automatic check_all_regs(input string tag);
    logic [N-1:0] v;
    rd(4'd1, v); chk({tag, " level reg"}, v, m_dout);
    rd(4'd2, v); chk({tag, " level reg alias"}, v, m_dout);
    rd(4'd3, v); chk({tag, " dir reg"}, v, m_dir);
    rd(4'd5, v); chk({tag, " sel low"}, v, m_lo);
    rd(4'd6, v); chk({tag, " sel high"}, v, m_hi);
    rd(4'd7, v); chk({tag, " pull-off"}, v, m_pull);
    rd(4'd8, v); chk({tag, " keep"}, v, m_keep);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v, eo, ee, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    m_dout = '0; m_dir = '0; m_lo = '0; m_hi = '0; m_pull = '0; m_keep = '1;
    check_all_regs("R1");
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pull_en", pad_pull_en, '1);
    chk("R1 pull_up", pad_pull_up, '0);

    // R2 / R3 set and clear with overlapping masks
    a = 32'h00FF_0F0F; b = 32'h0F0F_F0F0;
    wr(4'd1, a); m_dout = a;
    rd(4'd1, v); chk("R2 first set", v, m_dout);
    wr(4'd1, b); m_dout = a | b;
    rd(4'd2, v); chk("R2 accumulate", v, m_dout);
    wr(4'd2, 32'h0F00_0FF0); m_dout = m_dout & ~32'h0F00_0FF0;
    rd(4'd1, v); chk("R3 clear", v, m_dout);
    wr(4'd2, '0);
    rd(4'd1, v); chk("R3 zero clear no effect", v, m_dout);

    // R4 direction and GPIO drive
    wr(4'd3, 32'hFFFF_0000); m_dir = 32'hFFFF_0000;
    wr(4'd4, 32'h3000_0000); m_dir = m_dir & ~32'h3000_0000;
    rd(4'd4, v); chk("R4 dir readback", v, m_dir);
    #1; chk("R4 gpio oe", pad_oe, m_dir);
    chk("R4 gpio out", pad_out, m_dout);

    // R6 pull
    wr(4'd7, 32'hA5A5_0FF0); m_pull = 32'hA5A5_0FF0;
    #1; chk("R6 pull_en", pad_pull_en, ~m_pull);
    chk("R6 pull_up from level", pad_pull_up, m_dout);

    // R5 / R7 / R8 / R9 sweep over routes, override and keep masks
    for (int it = 0; it < 16; it++) begin
      seed = nxt(seed); m_lo = seed;
      seed = nxt(seed); m_hi = seed;
      seed = nxt(seed); m_keep = seed;
      seed = nxt(seed); a = seed;
      wr(4'd5, m_lo); wr(4'd6, m_hi); wr(4'd8, m_keep);
      wr(4'd2, '1); wr(4'd1, a); m_dout = a;
      seed = nxt(seed);
      wr(4'd4, '1); wr(4'd3, seed); m_dir = seed;
      @(negedge clk); #1;
      expect_pads(1'b0, eo, ee);
      chk("R5 route out", pad_out, eo); chk("R5 route oe", pad_oe, ee);
      force_sleep = 1; #1;
      expect_pads(1'b1, eo, ee);
      chk("R7 R8 forced out", pad_out, eo); chk("R7 R8 forced oe", pad_oe, ee);
      force_sleep = 0; #1;
      expect_pads(1'b0, eo, ee);
      chk("R9 release out", pad_out, eo); chk("R9 release oe", pad_oe, ee);
    end
    // R7 all forced, R8 all kept
    wr(4'd8, '0); m_keep = '0;
    force_sleep = 1; #1;
    chk("R7 all forced oe", pad_oe, m_dir); chk("R7 all forced out", pad_out, m_dout);
    wr(4'd8, '1); m_keep = '1; #1;
    expect_pads(1'b1, eo, ee);
    chk("R8 all kept oe", pad_oe, ee);
    force_sleep = 0;

    // R10 synchronizer depth
    pad_in = 32'h0000_0000;
    repeat (3) @(negedge clk);
    pad_in = 32'hC0DE_5EED;
    @(posedge clk); #1; chk("R10 after one edge", pin_level, 32'h0);
    @(posedge clk); #1; chk("R10 after two edges", pin_level, 32'hC0DE_5EED);
    @(negedge clk); rd(4'd0, v); chk("R10 bus read", v, 32'hC0DE_5EED);

    // R11 writes to read-only/unmapped ignored, unmapped reads zero
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd9, 32'h1234_5678);
    wr(4'd15, 32'hFFFF_FFFF);
    check_all_regs("R11");
    rd(4'd0, v); chk("R11 level unaffected", v, 32'hC0DE_5EED);
    rd(4'd12, v); chk("R11 unmapped read", v, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule